// File: doc/BRIEF.md
# Data Width Adapter for a DMA Channel

This block sits in the data path of a DMA channel. It turns a stream of source beats of one width into a stream of destination beats of another width. Each width is a byte, a half-word or a word. A 2-bit format field selects the conversion, and its meaning depends on which side is narrower. A narrower source can be zero-padded, sign-extended or packed. A wider source can keep its low part, keep its high part or be unpacked. Three swap controls can reorder bytes. One acts on the source beat before conversion, and two act on the destination beat after it.

Both streams use valid/ready handshakes. A source beat moves when `s_valid` and `s_ready` are both high at a rising clock edge. A destination beat moves when `m_valid` and `m_ready` are both high. Once `m_valid` is raised, the destination beat and its strobe and last flag do not change until the beat is taken. `s_ready` drops whenever a destination beat is waiting and `m_ready` is low. It also drops while the pieces of an unpacked source beat are still being sent. All configuration inputs are static: they change only while no transfer is in progress. Data sits right-aligned on both buses, so a beat of N bytes occupies byte lanes 0 to N-1.

Top module: `dwa_width_adapter`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1. While `m_valid` is high and `m_ready` is low, `m_data`, `m_strb` and `m_last` hold their values and `s_ready` is low.
- R2: Size codes are 0 byte, 1 half-word and 2 word. When the source and destination sizes are equal, the source lanes are copied to the same destination lanes and the strobe enables all destination lanes. In every mode, `s_data` lanes above the source size are ignored and `m_data` lanes above the destination size are zero.
- R3: Format 0 with a narrower source places the source in the low lanes and fills the upper destination lanes with zero.
- R4: Format 1 with a narrower source places the source in the low lanes and fills the upper destination lanes with copies of the top bit of the source.
- R5: Format 0 with a wider source outputs the low destination-size bytes of the source beat.
- R6: Format 1 with a wider source outputs the high destination-size bytes of the source beat.
- R7: Format 2 with a narrower source packs consecutive source beats into one destination beat, filling from lane 0 upward. A destination beat is sent as soon as it is full, and it carries `m_last` if the beat that completed it had `s_last`.
- R8: In packing, a source beat with `s_last` that leaves the destination beat partly filled causes that beat to be sent with `m_last` set and only the filled lanes enabled in `m_strb`.
- R9: Format 2 with a wider source splits each source beat into source/destination-size destination beats, least significant part first. Only the final part of a beat with `s_last` carries `m_last`.
- R10: Format 3 behaves as format 0, and size code 3 behaves as word.
- R11: With `cfg_src_swap` set and a word source, source lanes 0..3 are reversed before conversion. The control has no effect for a byte or half-word source.
- R12: With `cfg_dst_swap_b` set and a destination of half-word or word, each pair of lanes (0,1) and (2,3) is exchanged after conversion, in both `m_data` and `m_strb`. The control has no effect for a byte destination.
- R13: With `cfg_dst_swap_h` set and a word destination, lanes 1:0 exchange with lanes 3:2 after conversion, in both `m_data` and `m_strb`. The control has no effect otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Format field: 0 right/zero, 1 alternate, 2 pack/unpack, 3 as 0 |
| cfg_src_size | input | 2 | Source beat size code |
| cfg_dst_size | input | 2 | Destination beat size code |
| cfg_src_swap | input | 1 | Reverse byte order of a word source |
| cfg_dst_swap_b | input | 1 | Exchange bytes within each destination half-word |
| cfg_dst_swap_h | input | 1 | Exchange half-words of a word destination |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Source beat accepted when high with s_valid |
| s_data | input | 32 | Source beat, right-aligned |
| s_last | input | 1 | Final source beat of a transfer |
| m_valid | output | 1 | Destination beat valid |
| m_ready | input | 1 | Destination consumer ready |
| m_data | output | 32 | Destination beat |
| m_strb | output | 4 | Byte-lane enables of the destination beat |
| m_last | output | 1 | Final destination beat of a transfer |

## Verification
The bench goes after the sign bit at the top of a byte or half-word source. A design that extended from the wrong bit would output wrong fill bytes. It checks a packing transfer that ends after one or three bytes. Here a design that waited for a full word would hang, and one with wrong strobes would enable lanes it never filled. It stalls the destination in the middle of an unpack. A design that took a new source beat or lost a piece would show a wrong or missing part. Random swap settings with every size pair check where the strobe bits land on a flushed partial beat, and that a swap is ignored when a side is too narrow for it.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  // Format field values
  typedef enum logic [1:0] {
    FMT_RIGHT = 2'd0,
    FMT_ALT   = 2'd1,
    FMT_PACK  = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_mode_e;

  // Beat size codes
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_code_e;

endpackage

// File: rtl/dwa_size_dec.sv
module dwa_size_dec #(
  parameter int LANES = 4,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [1:0]    size_code,
  output logic [CW-1:0] size_bytes
);
  import dwa_pkg::*;

  always_comb begin
    unique case (size_code)
      SZ_BYTE: size_bytes = CW'(1);
      SZ_HALF: size_bytes = CW'(2);
      default: size_bytes = CW'(4);   // word and reserved code
    endcase
  end

endmodule

// File: rtl/dwa_lane_xor.sv
// Permutes LANES groups of GW bits: output group i takes input group i ^ xmask.
module dwa_lane_xor #(
  parameter int LANES = 4,
  parameter int GW    = 8,
  localparam int LW   = $clog2(LANES),
  localparam int VW   = LANES * GW
) (
  input  logic [LW-1:0] xmask,
  input  logic [VW-1:0] vec_in,
  output logic [VW-1:0] vec_out
);

  always_comb begin
    vec_out = '0;
    for (int i = 0; i < LANES; i++) begin
      vec_out[GW*i +: GW] = vec_in[GW*(i ^ int'(xmask)) +: GW];
    end
  end

endmodule

// File: rtl/dwa_core.sv
module dwa_core #(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [CW-1:0]    src_bytes,
  input  logic [CW-1:0]    dst_bytes,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [LANES-1:0] out_strb,
  output logic             out_last
);
  import dwa_pkg::*;

  function automatic logic [DW-1:0] bit_mask(input logic [CW-1:0] n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) if (i < int'(n)) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [CW-1:0] n);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  // Output register
  logic             ov_q, olast_q;
  logic [DW-1:0]    od_q;
  logic [LANES-1:0] os_q;

  // Pack accumulator
  logic [DW-1:0]    pk_data_q;
  logic [LANES-1:0] pk_strb_q;
  logic [CW-1:0]    pk_cnt_q;

  // Unpack holding register
  logic             up_busy_q, up_last_q;
  logic [DW-1:0]    up_data_q;
  logic [CW-1:0]    up_left_q;

  // Combinational decode
  logic [DW-1:0]    mask_s, mask_d, dm, conv, pk_data_n;
  logic [LANES-1:0] lm_d, pk_strb_n;
  logic [CW-1:0]    pk_cnt_n, pieces;
  logic             sign_bit, narrow, wide, sel_alt, sel_pack, do_pack, do_unpack;
  logic             out_free, take;

  always_comb begin
    mask_s   = bit_mask(src_bytes);
    mask_d   = bit_mask(dst_bytes);
    lm_d     = lane_mask(dst_bytes);
    dm       = in_data & mask_s;
    narrow   = src_bytes < dst_bytes;
    wide     = src_bytes > dst_bytes;
    sel_alt  = mode == FMT_ALT;
    sel_pack = mode == FMT_PACK;
    do_pack   = narrow && sel_pack;
    do_unpack = wide && sel_pack;

    sign_bit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (i + 1 == int'(src_bytes)) sign_bit = dm[8*i + 7];
    end

    if (narrow && sel_alt)
      conv = (dm | (sign_bit ? ~mask_s : '0)) & mask_d;
    else if (wide && sel_alt)
      conv = (dm >> (8 * (int'(src_bytes) - int'(dst_bytes)))) & mask_d;
    else
      conv = dm & mask_d;

    pk_data_n = pk_data_q | (dm << (8 * int'(pk_cnt_q)));
    pk_strb_n = pk_strb_q | (lane_mask(src_bytes) << pk_cnt_q);
    pk_cnt_n  = pk_cnt_q + src_bytes;

    pieces = '0;
    for (int k = 1; k <= LANES; k++) begin
      if (k * int'(dst_bytes) == int'(src_bytes)) pieces = CW'(k);
    end
  end

  assign out_free = !ov_q || out_ready;
  assign in_ready = out_free && !up_busy_q;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q      <= 1'b0;
      olast_q   <= 1'b0;
      od_q      <= '0;
      os_q      <= '0;
      pk_data_q <= '0;
      pk_strb_q <= '0;
      pk_cnt_q  <= '0;
      up_busy_q <= 1'b0;
      up_last_q <= 1'b0;
      up_data_q <= '0;
      up_left_q <= '0;
    end else begin
      if (ov_q && out_ready) ov_q <= 1'b0;

      if (up_busy_q && out_free) begin
        ov_q      <= 1'b1;
        od_q      <= up_data_q & mask_d;
        os_q      <= lm_d;
        olast_q   <= up_last_q && (up_left_q == CW'(1));
        up_data_q <= up_data_q >> (8 * int'(dst_bytes));
        up_left_q <= up_left_q - CW'(1);
        if (up_left_q == CW'(1)) up_busy_q <= 1'b0;
      end else if (take) begin
        if (do_pack) begin
          if (pk_cnt_n >= dst_bytes || in_last) begin
            ov_q      <= 1'b1;
            od_q      <= pk_data_n;
            os_q      <= pk_strb_n;
            olast_q   <= in_last;
            pk_data_q <= '0;
            pk_strb_q <= '0;
            pk_cnt_q  <= '0;
          end else begin
            pk_data_q <= pk_data_n;
            pk_strb_q <= pk_strb_n;
            pk_cnt_q  <= pk_cnt_n;
          end
        end else if (do_unpack) begin
          ov_q      <= 1'b1;
          od_q      <= dm & mask_d;
          os_q      <= lm_d;
          olast_q   <= 1'b0;
          up_data_q <= dm >> (8 * int'(dst_bytes));
          up_left_q <= pieces - CW'(1);
          up_last_q <= in_last;
          up_busy_q <= 1'b1;
        end else begin
          ov_q    <= 1'b1;
          od_q    <= conv;
          os_q    <= lm_d;
          olast_q <= in_last;
        end
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_strb  = os_q;
  assign out_last  = olast_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q && !out_ready |=> ov_q && $stable(od_q) && $stable(os_q) && $stable(olast_q)); // R1
  AST_STRB_IN_DST: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> (os_q & ~lm_d) == '0); // R2
  AST_PACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pk_cnt_q < dst_bytes); // R7
  AST_UNPACK_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    up_busy_q && ov_q |-> !olast_q); // R9

endmodule

// File: rtl/dwa_width_adapter.sv
module dwa_width_adapter #(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES,
  localparam int CW   = $clog2(LANES + 1),
  localparam int LW   = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_src_size,
  input  logic [1:0]       cfg_dst_size,
  input  logic             cfg_src_swap,
  input  logic             cfg_dst_swap_b,
  input  logic             cfg_dst_swap_h,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  input  logic             s_last,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic [LANES-1:0] m_strb,
  output logic             m_last
);

  logic [CW-1:0]    src_bytes, dst_bytes;
  logic [LW-1:0]    src_xm, dst_xm;
  logic [DW-1:0]    src_sw, core_data;
  logic [LANES-1:0] core_strb;

  dwa_size_dec #(.LANES(LANES)) u_src_dec (.size_code(cfg_src_size), .size_bytes(src_bytes));
  dwa_size_dec #(.LANES(LANES)) u_dst_dec (.size_code(cfg_dst_size), .size_bytes(dst_bytes));

  // Swap masks: lane index XOR 3 reverses a word, XOR 1 swaps bytes, XOR 2 swaps halves
  always_comb begin
    src_xm = '0;
    dst_xm = '0;
    if (cfg_src_swap && src_bytes == CW'(4)) src_xm = LW'(3);
    dst_xm[0] = cfg_dst_swap_b && (dst_bytes >= CW'(2));
    dst_xm[1] = cfg_dst_swap_h && (dst_bytes == CW'(4));
  end

  dwa_lane_xor #(.LANES(LANES), .GW(8)) u_src_swap (
    .xmask(src_xm), .vec_in(s_data), .vec_out(src_sw)
  );

  dwa_core #(.LANES(LANES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_mode),
    .src_bytes(src_bytes),
    .dst_bytes(dst_bytes),
    .in_valid (s_valid),
    .in_ready (s_ready),
    .in_data  (src_sw),
    .in_last  (s_last),
    .out_valid(m_valid),
    .out_ready(m_ready),
    .out_data (core_data),
    .out_strb (core_strb),
    .out_last (m_last)
  );

  dwa_lane_xor #(.LANES(LANES), .GW(8)) u_dst_swap_d (
    .xmask(dst_xm), .vec_in(core_data), .vec_out(m_data)
  );
  dwa_lane_xor #(.LANES(LANES), .GW(1)) u_dst_swap_s (
    .xmask(dst_xm), .vec_in(core_strb), .vec_out(m_strb)
  );

  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready); // R1
  AST_SWAP_KEEPS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> $countones(m_strb) == $countones(core_strb)); // R12

endmodule

// File: tb/dwa_width_adapter_bench.sv
module dwa_width_adapter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0, cfg_src_size = '0, cfg_dst_size = '0;
  logic        cfg_src_swap = 1'b0, cfg_dst_swap_b = 1'b0, cfg_dst_swap_h = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, m_valid, m_last;
  logic [31:0] m_data;
  logic [3:0]  m_strb;

  int n_checks = 0;
  int n_fail   = 0;
  bit stall    = 1'b0;

  logic [31:0] q_data[$];
  logic [3:0]  q_strb[$];
  bit          q_last[$];
  string       q_tag[$];

  logic [7:0] pk[4];
  int         pk_fill = 0;

  always #4 clk = ~clk;   // 125 MHz

  dwa_width_adapter u_dwa_width_adapter (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode(cfg_mode), .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size),
    .cfg_src_swap(cfg_src_swap), .cfg_dst_swap_b(cfg_dst_swap_b), .cfg_dst_swap_h(cfg_dst_swap_h),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_strb(m_strb), .m_last(m_last)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int sz_bytes(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  function automatic void emit(input logic [7:0] db[4], input logic [3:0] st,
                               input bit last, input string tag);
    int d_b, xm;
    logic [31:0] od;
    logic [3:0]  os;
    string t;
    d_b = sz_bytes(cfg_dst_size);
    xm = 0;
    t = tag;
    if (cfg_dst_swap_b && d_b >= 2) begin xm = xm | 1; t = {t, "/R12"}; end
    if (cfg_dst_swap_h && d_b == 4) begin xm = xm | 2; t = {t, "/R13"}; end
    if (cfg_src_swap && sz_bytes(cfg_src_size) == 4) t = {t, "/R11"};
    if (cfg_src_size == 2'd3 || cfg_dst_size == 2'd3 || cfg_mode == 2'd3) t = {t, "/R10"};
    for (int j = 0; j < 4; j++) begin
      od[8*j +: 8] = db[j ^ xm];
      os[j]        = st[j ^ xm];
    end
    q_data.push_back(od);
    q_strb.push_back(os);
    q_last.push_back(last);
    q_tag.push_back(t);
  endfunction

  function automatic void model_beat(input logic [31:0] d, input bit last);
    logic [7:0] sb[4], tmp[4], db[4];
    int s, d_b;
    logic sg;
    logic [3:0] full;
    s   = sz_bytes(cfg_src_size);
    d_b = sz_bytes(cfg_dst_size);
    full = 4'((1 << d_b) - 1);
    for (int i = 0; i < 4; i++) sb[i] = (i < s) ? d[8*i +: 8] : 8'h00;
    if (cfg_src_swap && s == 4) begin
      for (int i = 0; i < 4; i++) tmp[i] = sb[3 - i];
      sb = tmp;
    end
    for (int i = 0; i < 4; i++) db[i] = 8'h00;
    if (s == d_b) begin
      for (int i = 0; i < d_b; i++) db[i] = sb[i];
      emit(db, full, last, "R2");
    end else if (s < d_b) begin
      if (cfg_mode == 2'd2) begin
        for (int i = 0; i < s; i++) pk[pk_fill + i] = sb[i];
        pk_fill += s;
        if (pk_fill == d_b || last) begin
          emit(pk, 4'((1 << pk_fill) - 1), last, (pk_fill < d_b) ? "R8" : "R7");
          for (int i = 0; i < 4; i++) pk[i] = 8'h00;
          pk_fill = 0;
        end
      end else if (cfg_mode == 2'd1) begin
        sg = sb[s - 1][7];
        for (int i = 0; i < d_b; i++) db[i] = (i < s) ? sb[i] : (sg ? 8'hFF : 8'h00);
        emit(db, full, last, "R4");
      end else begin
        for (int i = 0; i < s; i++) db[i] = sb[i];
        emit(db, full, last, "R3");
      end
    end else begin
      if (cfg_mode == 2'd2) begin
        for (int k = 0; k < s / d_b; k++) begin
          for (int i = 0; i < 4; i++) db[i] = (i < d_b) ? sb[k*d_b + i] : 8'h00;
          emit(db, full, last && (k == s / d_b - 1), "R9");
        end
      end else if (cfg_mode == 2'd1) begin
        for (int i = 0; i < d_b; i++) db[i] = sb[s - d_b + i];
        emit(db, full, last, "R6");
      end else begin
        for (int i = 0; i < d_b; i++) db[i] = sb[i];
        emit(db, full, last, "R5");
      end
    end
  endfunction

  // Destination side: pick m_ready at the falling edge, then compare taken beats
  always begin
    @(negedge clk);
    m_ready = stall ? 1'b0 : (($urandom % 4) != 0);
    #2;
    if (rst_n && m_valid && m_ready) begin
      if (q_data.size() == 0) begin
        check("R2", 1'b0, "unexpected beat", m_data, 32'h0);
      end else begin
        check(q_tag[0], m_data == q_data[0] && m_strb == q_strb[0] && m_last == q_last[0],
              $sformatf("beat strb=%b/%b last=%0d/%0d", m_strb, q_strb[0], m_last, q_last[0]),
              m_data, q_data[0]);
        void'(q_data.pop_front());
        void'(q_strb.pop_front());
        void'(q_last.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  task automatic send_beat(input logic [31:0] d, input bit last);
    bit acc;
    @(negedge clk); #1;
    s_valid = 1'b1;
    s_data  = d;
    s_last  = last;
    acc = 1'b0;
    while (!acc) begin
      #2;
      acc = s_ready;
      if (!acc) begin @(negedge clk); #1; end
    end
    model_beat(d, last);
  endtask

  task automatic idle_src();
    @(negedge clk); #1;
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_data  = $urandom;
  endtask

  task automatic drain();
    idle_src();
    while (q_data.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic [1:0] ss, input logic [1:0] ds,
                         input bit sw, input bit bx, input bit hx);
    cfg_mode = md; cfg_src_size = ss; cfg_dst_size = ds;
    cfg_src_swap = sw; cfg_dst_swap_b = bx; cfg_dst_swap_h = hx;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    int nb;
    void'($urandom(32'd20241));
    for (int i = 0; i < 4; i++) pk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R1: reset state
    check("R1", m_valid == 1'b0, "m_valid after reset", {31'b0, m_valid}, 32'h0);
    check("R1", s_ready == 1'b1, "s_ready after reset", {31'b0, s_ready}, 32'h1);

    // R4: sign bit at top of byte and half-word sources
    set_cfg(2'd1, 2'd0, 2'd2, 0, 0, 0);
    send_beat(32'h1234_5680, 0); send_beat(32'hFFFF_FF7F, 1); drain();
    set_cfg(2'd1, 2'd1, 2'd2, 0, 0, 0);
    send_beat(32'hAAAA_8001, 1); drain();
    // R8: packing that ends after one and three bytes, with swapped strobes
    set_cfg(2'd2, 2'd0, 2'd2, 0, 0, 1);
    send_beat(32'h0000_0011, 1); drain();
    set_cfg(2'd2, 2'd0, 2'd2, 0, 1, 0);
    send_beat(32'h0000_00A1, 0); send_beat(32'h0000_00B2, 0); send_beat(32'h0000_00C3, 1); drain();
    // R7: full packing of half-words
    set_cfg(2'd2, 2'd1, 2'd2, 0, 0, 0);
    send_beat(32'hDEAD_1234, 0); send_beat(32'hBEEF_5678, 1); drain();
    // R11/R6: source reversal before left-aligned truncation
    set_cfg(2'd1, 2'd2, 2'd0, 1, 1, 1);
    send_beat(32'h1122_3344, 1); drain();

    // R1/R9: stall in the middle of an unpack
    set_cfg(2'd2, 2'd2, 2'd0, 0, 0, 0);
    stall = 1'b1;
    send_beat(32'h8877_6655, 1);
    idle_src();
    repeat (2) @(negedge clk);
    #3;
    snap = m_data;
    check("R1", m_valid == 1'b1, "valid held in stall", {31'b0, m_valid}, 32'h1);
    check("R1", s_ready == 1'b0, "s_ready low in stall", {31'b0, s_ready}, 32'h0);
    repeat (4) @(negedge clk);
    #3;
    check("R1", m_data == snap, "data held in stall", m_data, snap);
    stall = 1'b0;
    drain();

    // Random transfers over all configurations
    for (int t = 0; t < 400; t++) begin
      set_cfg(2'($urandom % 4), 2'($urandom % 4), 2'($urandom % 4),
              1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      nb = 1 + int'($urandom % 6);
      for (int b = 0; b < nb; b++) begin
        send_beat($urandom, b == nb - 1);
        if (($urandom % 4) == 0) idle_src();
      end
      drain();
    end

    check("R2", q_data.size() == 0, "queue empty at end", q_data.size(), 32'h0);
    finish_run();
  end

endmodule